// File: doc/BRIEF.md
# Entropy Pool and Conditioning Sequencer

This block gathers jitter from a bank of free-running oscillator lanes into a 128-bit shift-register pool. It then hands pool snapshots, at a fixed cadence, to an iterative mixing stage. The mixing stage stands in for a cryptographic hash. Each mixed 64-bit result goes into a 64-word output queue, which software drains with a read strobe. The queue shows its head word on the data output. The level output and the valid output tell the reader when words are waiting.

Two controls change what the chain produces. When the entropy control is low, the oscillators are cut off from the pool. The pool then steps only from its fixed seed, and the output words form a repeatable known-answer sequence for a power-on self-test. The raw-mode control bypasses both the pool and the mixer. In raw mode, one byte-wide oscillator group, picked by a select input, is sampled on each clock, and every eight bytes form a queue word.

A flush command restarts the whole chain and empties the queue. Both controls are sampled at a flush and at the end of each timing window, never in the middle of a window.

Top module: `entropy_cond_seq`

## Requirements
- R1: While reset is high and after it, `valid_o` and `ovf_o` are 0, `level_o` is 0 and `data_o` is 0.
- R2: In conditioned mode the pool updates once per clock. The pool shifts left by one bit and the new bit 0 is the XOR of bits 127, 125, 100 and 98. After reset or flush the pool holds the seed 128'h6A09E667F3BCC908_BB67AE8584CAA73B. When entropy is latched on, each update is also XORed with oscillator lanes 0..124. Lanes 125..127 never reach the pool.
- R3: After a reset or flush in conditioned mode, the first mixed word enters the queue on the 162nd rising edge after the flush or reset edge. `valid_o` stays low before that edge.
- R4: Each later mixed word enters the queue exactly 81 edges after the one before it.
- R5: The mixer takes the pool value left after 81 updates. It starts from the upper half XOR the lower half. It then applies 81 rounds, where each round rotates left by 7 and adds 64'h9E3779B97F4A7C15 modulo 2^64.
- R6: With entropy off, the first and second words are fixed known answers that depend only on the seed, whatever the oscillator inputs do.
- R7: In raw mode the block takes byte `osc_i[8g+7:8g]` on each edge, where g is `grp_sel_i`. Every 8 edges it pushes one 64-bit word, with the earliest byte in bits 63:56. The first push comes 8 edges after the flush. All 128 lanes can be sampled this way.
- R8: The mode and entropy controls are latched only at a flush or at the end of the current window, which is 81 edges in conditioned mode and 8 in raw mode. A change made inside a window does not affect that window's output.
- R9: The queue holds 64 words in arrival order. `level_o` counts the stored words, `valid_o` is high when the level is nonzero, `data_o` shows the oldest word, and a read strobe removes it at the next edge.
- R10: A word that arrives while the queue is full and no read is taking place is dropped. The drop sets `ovf_o`, which stays high until a reset or flush.
- R11: When the queue is empty, `data_o` is 0 and a read strobe changes nothing.
- R12: A flush empties the queue, clears `ovf_o`, reloads the seed and restarts the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | 128 | Oscillator sample lanes |
| ent_en_i | input | 1 | Entropy enable request |
| raw_mode_i | input | 1 | Raw mode request (1 = bypass the mixer) |
| grp_sel_i | input | 4 | Raw sampling group select |
| flush_i | input | 1 | Restart the chain and empty the queue |
| rd_i | input | 1 | Read strobe that pops the head word |
| data_o | output | 64 | Head word of the queue, or 0 when empty |
| valid_o | output | 1 | Queue holds at least one word |
| level_o | output | 7 | Number of stored words (0..64) |
| ovf_o | output | 1 | Sticky flag for a dropped word |

## Verification
Each result has its own deadline, counted in rising edges from the reset or flush edge. A conditioned word is due at edge 162 and then at every 81st edge after that. A raw word is due at every 8th edge. A pop or a drop shows on `level_o` and `ovf_o` one edge after the strobe. The bench counts exactly those edges and samples on the following falling edge. For the conditioned word it also samples one edge early and expects no word yet. This way a design that is one cycle early or one cycle late fails a check. The expected conditioned words come from a separate model of the pool and mixer inside the bench, and the known-answer words are compared under several oscillator patterns.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int POOL_W     = 128;
    localparam int WORD_W     = 64;
    localparam int LANES_USED = 125;
    localparam int WIN_CYC    = 81;
    localparam int MIX_CYC    = 81;
    localparam int RAW_CYC    = 8;
    localparam int BYTE_W     = 8;
    localparam int GRP_N      = POOL_W / BYTE_W;
    localparam int FIFO_DEPTH = 64;

    localparam int CNT_W = $clog2(WIN_CYC);
    localparam int GRP_W = $clog2(GRP_N);
    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int LVL_W = PTR_W + 1;

    localparam int TAP_A = 127;
    localparam int TAP_B = 125;
    localparam int TAP_C = 100;
    localparam int TAP_D = 98;

    localparam logic [POOL_W-1:0] POOL_SEED = 128'h6A09E667F3BCC908_BB67AE8584CAA73B;
    localparam logic [POOL_W-1:0] LANE_MASK =
        {{(POOL_W-LANES_USED){1'b0}}, {LANES_USED{1'b1}}};
    localparam logic [WORD_W-1:0] MIX_K = 64'h9E3779B97F4A7C15;
    localparam int MIX_ROT = 7;

    typedef enum logic {
        MODE_COND = 1'b0,
        MODE_RAW  = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  ent;
    } ctl_s;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } word_s;

    function automatic logic [POOL_W-1:0] lfsr_next(input logic [POOL_W-1:0] p);
        logic fb;
        fb = p[TAP_A] ^ p[TAP_B] ^ p[TAP_C] ^ p[TAP_D];
        return {p[POOL_W-2:0], fb};
    endfunction

    function automatic logic [WORD_W-1:0] mix_fold(input logic [POOL_W-1:0] s);
        return s[POOL_W-1:WORD_W] ^ s[WORD_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] mix_round(input logic [WORD_W-1:0] a);
        return {a[WORD_W-1-MIX_ROT:0], a[WORD_W-1:WORD_W-MIX_ROT]} + MIX_K;
    endfunction

endpackage

// File: rtl/ecs_seq.sv
module ecs_seq
    import ecs_pkg::*;
#(
    parameter int WIN = WIN_CYC,
    parameter int RAW = RAW_CYC,
    parameter int CW  = CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic raw_req,
    input  logic ent_req,
    output ctl_s ctl,
    output logic wrap
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Window length follows the mode latched for the current window.
    assign last = (ctl.mode == MODE_RAW) ? CW'(RAW - 1) : CW'(WIN - 1);
    assign wrap = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ctl <= '{mode: MODE_COND, ent: 1'b0};
        end else if (flush || wrap) begin
            cnt <= '0;
            ctl <= '{mode: mode_e'(raw_req), ent: ent_req};
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ecs_pool.sv
module ecs_pool
    import ecs_pkg::*;
#(
    parameter int PW = POOL_W
) (
    input  logic          clk,
    input  logic          clr,
    input  ctl_s          ctl,
    input  logic [PW-1:0] osc,
    output logic [PW-1:0] pool_nx
);

    logic [PW-1:0] pool;
    logic [PW-1:0] stir;

    assign stir    = ctl.ent ? (osc & LANE_MASK) : '0;
    assign pool_nx = lfsr_next(pool) ^ stir;

    always_ff @(posedge clk) begin
        if (clr) begin
            pool <= POOL_SEED;
        end else if (ctl.mode == MODE_COND) begin
            pool <= pool_nx;
        end
    end

endmodule

// File: rtl/ecs_mixer.sv
module ecs_mixer
    import ecs_pkg::*;
#(
    parameter int PW     = POOL_W,
    parameter int WW     = WORD_W,
    parameter int ROUNDS = MIX_CYC
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          load,
    input  logic [PW-1:0] snap,
    output word_s         res
);

    localparam int RW = $clog2(ROUNDS + 1);

    logic [WW-1:0] acc;
    logic [RW-1:0] left;
    logic          busy;

    // The last round is folded into the push so the word lands on edge ROUNDS.
    assign res.vld  = busy && (left == RW'(1));
    assign res.data = mix_round(acc);

    always_ff @(posedge clk) begin
        if (clr) begin
            acc  <= '0;
            left <= '0;
            busy <= 1'b0;
        end else if (load) begin
            acc  <= mix_fold(snap);
            left <= RW'(ROUNDS);
            busy <= 1'b1;
        end else if (busy) begin
            acc  <= mix_round(acc);
            left <= left - 1'b1;
            busy <= (left != RW'(1));
        end
    end

endmodule

// File: rtl/ecs_raw.sv
module ecs_raw
    import ecs_pkg::*;
#(
    parameter int PW = POOL_W,
    parameter int BW = BYTE_W,
    parameter int GN = GRP_N,
    parameter int GW = GRP_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          active,
    input  logic          wrap,
    input  logic [GW-1:0] grp,
    input  logic [PW-1:0] osc,
    output word_s         res
);

    localparam int SH_W = WW - BW;

    logic [BW-1:0]   lane_grp [GN];
    logic [BW-1:0]   pick;
    logic [SH_W-1:0] sh;

    for (genvar g = 0; g < GN; g++) begin : g_grp
        assign lane_grp[g] = osc[g*BW +: BW];
    end

    assign pick     = lane_grp[grp];
    assign res.vld  = active && wrap;
    assign res.data = {sh, pick};

    always_ff @(posedge clk) begin
        if (clr) begin
            sh <= '0;
        end else if (active) begin
            sh <= {sh[SH_W-BW-1:0], pick};
        end
    end

endmodule

// File: rtl/ecs_fifo.sv
module ecs_fifo
    import ecs_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int AW    = PTR_W,
    parameter int LW    = LVL_W
) (
    input  logic          clk,
    input  logic          clr,
    input  word_s         wr,
    input  logic          rd_req,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level,
    output logic          ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          pop;
    logic          accept;

    assign pop    = rd_req && (level != '0);
    assign accept = wr.vld && ((level != LW'(DEPTH)) || pop);
    assign dout   = (level != '0) ? mem[rp] : '0;

    always_ff @(posedge clk) begin
        if (accept && !clr) begin
            mem[wp] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) wp <= wp + 1'b1;
            if (pop)    rp <= rp + 1'b1;
            case ({accept, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr.vld && !accept) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/entropy_cond_seq.sv
module entropy_cond_seq
    import ecs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [POOL_W-1:0]   osc_i,
    input  logic                ent_en_i,
    input  logic                raw_mode_i,
    input  logic [GRP_W-1:0]    grp_sel_i,
    input  logic                flush_i,
    input  logic                rd_i,
    output logic [WORD_W-1:0]   data_o,
    output logic                valid_o,
    output logic [LVL_W-1:0]    level_o,
    output logic                ovf_o
);

    ctl_s              ctl;
    logic              wrap;
    logic              clr;
    logic              mix_load;
    logic [POOL_W-1:0] pool_nx;
    word_s             mix_res;
    word_s             raw_res;
    word_s             push;

    assign clr = rst || flush_i;
    // A conditioned window starts the mixer only if the next window stays conditioned.
    assign mix_load = wrap && (ctl.mode == MODE_COND) && !raw_mode_i;

    ecs_seq #(.WIN(WIN_CYC), .RAW(RAW_CYC), .CW(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_i),
        .raw_req (raw_mode_i),
        .ent_req (ent_en_i),
        .ctl     (ctl),
        .wrap    (wrap)
    );

    ecs_pool #(.PW(POOL_W)) u_pool (
        .clk     (clk),
        .clr     (clr),
        .ctl     (ctl),
        .osc     (osc_i),
        .pool_nx (pool_nx)
    );

    ecs_mixer #(.PW(POOL_W), .WW(WORD_W), .ROUNDS(MIX_CYC)) u_mix (
        .clk  (clk),
        .clr  (clr),
        .load (mix_load),
        .snap (pool_nx),
        .res  (mix_res)
    );

    ecs_raw #(.PW(POOL_W), .BW(BYTE_W), .GN(GRP_N), .GW(GRP_W), .WW(WORD_W)) u_raw (
        .clk    (clk),
        .clr    (clr),
        .active (ctl.mode == MODE_RAW),
        .wrap   (wrap),
        .grp    (grp_sel_i),
        .osc    (osc_i),
        .res    (raw_res)
    );

    // The two producers never push on the same edge: raw pushes need raw mode latched.
    assign push = raw_res.vld ? raw_res : mix_res;

    ecs_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH), .AW(PTR_W), .LW(LVL_W)) u_fifo (
        .clk    (clk),
        .clr    (clr),
        .wr     (push),
        .rd_req (rd_i),
        .dout   (data_o),
        .level  (level_o),
        .ovf    (ovf_o)
    );

    assign valid_o = (level_o != '0);

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
    parameter int LW    = 7,
    parameter int DW    = 64,
    parameter int DEPTH = 64,
    parameter int FIRST = 162
) (
    input logic          clk,
    input logic          rst,
    input logic          flush_i,
    input logic          raw_mode_i,
    input logic          rd_i,
    input logic          valid_o,
    input logic [DW-1:0] data_o,
    input logic [LW-1:0] level_o,
    input logic          ovf_o
);

    logic [8:0] since;
    logic       raw_seen;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            since    <= '0;
            raw_seen <= flush_i && raw_mode_i;
        end else begin
            if (since != 9'h1FF) since <= since + 1'b1;
            raw_seen <= raw_seen || raw_mode_i;
        end
    end

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst || flush_i)
        (!raw_seen && (since < 9'(FIRST))) |-> !valid_o); // R3
    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
        level_o <= LW'(DEPTH)); // R9
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (data_o == '0)); // R11
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && rd_i && !flush_i) |=> (level_o <= LW'(1))); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !flush_i) |=> ovf_o); // R10
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> ((level_o == '0) && !ovf_o)); // R12

endmodule

bind entropy_cond_seq ecs_checker #(
    .LW(ecs_pkg::LVL_W), .DW(ecs_pkg::WORD_W), .DEPTH(ecs_pkg::FIFO_DEPTH),
    .FIRST(ecs_pkg::WIN_CYC + ecs_pkg::MIX_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .raw_mode_i (raw_mode_i),
    .rd_i       (rd_i),
    .valid_o    (valid_o),
    .data_o     (data_o),
    .level_o    (level_o),
    .ovf_o      (ovf_o)
);

// File: tb/sim_entropy_cond_seq.sv
module sim_entropy_cond_seq;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] osc_i;
    logic         ent_en_i;
    logic         raw_mode_i;
    logic [3:0]   grp_sel_i;
    logic         flush_i;
    logic         rd_i;
    logic [63:0]  data_o;
    logic         valid_o;
    logic [6:0]   level_o;
    logic         ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    entropy_cond_seq u0 (
        .clk(clk), .rst(rst), .osc_i(osc_i), .ent_en_i(ent_en_i),
        .raw_mode_i(raw_mode_i), .grp_sel_i(grp_sel_i), .flush_i(flush_i),
        .rd_i(rd_i), .data_o(data_o), .valid_o(valid_o), .level_o(level_o),
        .ovf_o(ovf_o)
    );

    localparam logic [127:0] SEED = 128'h6A09E667F3BCC908_BB67AE8584CAA73B;
    localparam logic [127:0] PAT  = 128'h0123456789ABCDEF_FEDCBA9876543210;
    localparam logic [127:0] PAT2 = 128'h00000000_00000000_00000000_FF000000;

    typedef struct packed {
        logic [3:0]   g;
        logic [127:0] osc;
        logic [63:0]  exp;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{4'd0,  PAT,  64'h1010101010101010},
        '{4'd7,  PAT,  64'hFEFEFEFEFEFEFEFE},
        '{4'd10, PAT,  64'hABABABABABABABAB},
        '{4'd15, PAT,  64'h0101010101010101},
        '{4'd3,  PAT2, 64'hFFFFFFFFFFFFFFFF},
        '{4'd4,  PAT2, 64'h0000000000000000}
    };

    function automatic logic [127:0] m_run(input logic [127:0] p, input int n,
                                           input logic [127:0] x);
        logic [127:0] q = p;
        logic [127:0] xm = x & ~(128'h7 << 125);
        for (int i = 0; i < n; i++) begin
            q = {q[126:0], q[127] ^ q[125] ^ q[100] ^ q[98]} ^ xm;
        end
        return q;
    endfunction

    function automatic logic [63:0] m_mix(input logic [127:0] s);
        logic [63:0] a = s[127:64] ^ s[63:0];
        for (int i = 0; i < 81; i++) begin
            a = {a[56:0], a[63:57]} + 64'h9E3779B97F4A7C15;
        end
        return a;
    endfunction

    function automatic logic [63:0] rep(input logic [7:0] b);
        return {8{b}};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic pop_one();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R3 actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] p81;
        logic [63:0]  kat1, kat2;
        p81  = m_run(SEED, 81, '0);
        kat1 = m_mix(p81);
        kat2 = m_mix(m_run(p81, 81, '0));

        rst = 1'b1; flush_i = 1'b0; rd_i = 1'b0; raw_mode_i = 1'b0;
        ent_en_i = 1'b0; grp_sel_i = '0; osc_i = PAT;
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(valid_o), 64'd0);
        chk("R1 level", 64'(level_o), 64'd0);
        chk("R1 data", data_o, 64'd0);
        chk("R1 ovf", 64'(ovf_o), 64'd0);
        rst = 1'b0;

        // Known answer from reset, oscillators disconnected
        repeat (161) @(negedge clk);
        chk("R3 no word at edge 161", 64'(valid_o), 64'd0);
        @(negedge clk);
        chk("R3 word at edge 162", 64'(valid_o), 64'd1);
        chk("R6 R5 first known answer", data_o, kat1);
        repeat (80) @(negedge clk);
        chk("R4 no second word at +80", 64'(level_o), 64'd1);
        @(negedge clk);
        chk("R4 second word at +81", 64'(level_o), 64'd2);
        pop_one();
        chk("R6 second known answer", data_o, kat2);
        chk("R9 level after pop", 64'(level_o), 64'd1);

        // Lanes 125..127 must not reach the pool
        ent_en_i = 1'b1; osc_i = 128'h7 << 125;
        do_flush();
        chk("R12 flush empties", 64'(level_o), 64'd0);
        repeat (162) @(negedge clk);
        chk("R2 ignored lanes", data_o, kat1);

        // Lane 0 stirred into every update
        osc_i = 128'h1;
        do_flush();
        repeat (162) @(negedge clk);
        chk("R2 lane 0 stirred", data_o, m_mix(m_run(SEED, 81, 128'h1)));

        // Entropy raised mid-window takes effect at the next window
        ent_en_i = 1'b0;
        do_flush();
        repeat (10) @(negedge clk);
        ent_en_i = 1'b1;
        repeat (152) @(negedge clk);
        chk("R8 window keeps latched entropy", data_o, kat1);
        repeat (81) @(negedge clk);
        chk("R8 level", 64'(level_o), 64'd2);
        pop_one();
        chk("R8 next window uses entropy", data_o, m_mix(m_run(p81, 81, 128'h1)));

        // Raw sampling table
        ent_en_i = 1'b0; raw_mode_i = 1'b1;
        do_flush();
        for (int i = 0; i < 6; i++) begin
            osc_i = VT[i].osc; grp_sel_i = VT[i].g;
            repeat (8) begin
                @(negedge clk);
                rd_i = 1'b0;
            end
            chk("R7 raw batch level", 64'(level_o), 64'd1);
            chk("R7 raw batch word", data_o, VT[i].exp);
            rd_i = 1'b1;
        end
        @(negedge clk);
        rd_i = 1'b0;

        // Raw to conditioned switch inside a raw window
        osc_i = 128'h1; grp_sel_i = 4'd0; raw_mode_i = 1'b1;
        do_flush();
        repeat (3) @(negedge clk);
        raw_mode_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 raw word before switch", data_o, rep(8'h01));
        repeat (161) @(negedge clk);
        chk("R8 no mixed word yet", 64'(level_o), 64'd1);
        @(negedge clk);
        chk("R8 mixed word after switch", 64'(level_o), 64'd2);
        pop_one();
        chk("R8 known answer after switch", data_o, kat1);

        // Fill, overflow, drain, empty read
        raw_mode_i = 1'b1;
        do_flush();
        for (int k = 0; k < 65; k++) begin
            osc_i = 128'(k + 1);
            if (k == 64) raw_mode_i = 1'b0;
            repeat (8) @(negedge clk);
        end
        chk("R10 full level", 64'(level_o), 64'd64);
        chk("R10 overflow flag", 64'(ovf_o), 64'd1);
        for (int j = 0; j < 64; j++) begin
            chk("R9 order", data_o, rep(8'(j + 1)));
            pop_one();
        end
        chk("R11 empty data", data_o, 64'd0);
        chk("R11 empty valid", 64'(valid_o), 64'd0);
        pop_one();
        chk("R11 read on empty keeps level", 64'(level_o), 64'd0);
        chk("R10 overflow sticky", 64'(ovf_o), 64'd1);
        do_flush();
        chk("R12 flush clears overflow", 64'(ovf_o), 64'd0);
        chk("R12 flush clears valid", 64'(valid_o), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule